// File: doc/BRIEF.md
# Dual-Divisor Asynchronous Serial Port with Loopback

This block is an 8-bit asynchronous serial transmitter and receiver. The transmit and receive bit rates are set on their own: each is a 15-bit divisor, and both divisors are packed into one 32-bit word. Every frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit (even or odd) and one high stop bit. The transmitter has a single holding register in front of its shift register. The receiver has a single data register, and reports overrun and framing faults.

Control inputs do the following:
- enable the transmitter and the receiver separately;
- send a break, which holds the line low;
- drive a request-to-send output;
- select an internal loopback, which feeds the transmitter into the receiver;
- apply a synchronous soft reset.

Five status levels are brought out as plain outputs, so an interrupt controller can mask and latch any of them: receive ready, transmit ready, transmit empty, overrun and framing error. Software writes a byte with a one-cycle strobe and takes a received byte with a one-cycle read strobe.

Top module: `dual_rate_uart`

## Requirements
- R1: After `rstN` is low, the outputs settle to these values: `serialOut`=1, `txReady`=1, `txEmpty`=1, `rxReady`=0, `rxOverrun`=0, `frameErr`=0, `rtsOut`=0.
- R2: The transmit divisor is `baudWord[14:0]` and the receive divisor is `baudWord[30:16]`. Each bit lasts divisor+1 clocks, and the two divisors act independently.
- R3: A transmitted frame is built as follows. The idle line is 1. The start bit is 0. The data bits go out in the order bit 0 first, bit 7 last. Next comes the parity bit, only when `parityOn`=1. The frame ends with a stop bit of 1.
- R4: When `parityEven`=1, the parity bit makes the count of ones in data plus parity even. When `parityEven`=0, it makes that count odd. The receiver checks parity in the same way.
- R5: `txReady`=1 means the holding register is free. `txEmpty`=1 means the holding register is free and no frame is in progress. A `txWrite` while `txReady`=0 is ignored.
- R6: While `txBreak`=1, `serialOut` is 0 and no new frame is started. A byte that is waiting is sent after the break is released.
- R7: While `txEnable`=0, no frame starts and the line stays at 1. While `rxEnable`=0, the receiver ignores the line and captures nothing.
- R8: The receiver finds a falling start edge and samples each bit near its middle. On the stop bit it loads `rxData` and raises `rxReady`. A `rxRead` pulse clears `rxReady`, `rxOverrun` and `frameErr`.
- R9: A frame that completes while `rxReady`=1 sets `rxOverrun`. That new byte is discarded, and `rxData` keeps the unread byte.
- R10: `frameErr` is set with the stored byte when the stop bit is sampled as 0, or when parity is enabled and the received parity bit is wrong.
- R11: With `loopMode`=1, the receiver takes the transmitter's line (break included) and ignores `serialIn`, while `serialOut` stays at 1.
- R12: `rtsOut` follows `rtsReq` one clock later.
- R13: A `softReset` pulse aborts both frames, empties the holding register and clears all receive flags. The outputs then match the values listed in R1, except `rtsOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudWord | input | 32 | Transmit divisor in [14:0], receive divisor in [30:16] |
| parityOn | input | 1 | Adds a parity bit to frames and checks it on receive |
| parityEven | input | 1 | 1 selects even parity, 0 selects odd parity |
| rtsReq | input | 1 | Requested level for the request-to-send line |
| txEnable | input | 1 | Allows new transmit frames to start |
| rxEnable | input | 1 | Allows the receiver to run |
| txBreak | input | 1 | Holds the line low and blocks new frames |
| loopMode | input | 1 | Routes the transmitter into the receiver internally |
| softReset | input | 1 | Synchronous reinitialisation of the port |
| txWrite | input | 1 | Strobe that loads `txData` into the holding register |
| txData | input | 8 | Byte to transmit |
| rxRead | input | 1 | Strobe that consumes the received byte and clears receive flags |
| rxData | output | 8 | Last stored received byte |
| rxReady | output | 1 | A received byte is waiting |
| txReady | output | 1 | The holding register is free |
| txEmpty | output | 1 | The holding register is free and the transmitter is idle |
| rxOverrun | output | 1 | A byte arrived while the previous one was unread |
| frameErr | output | 1 | The stored byte had a low stop bit or bad parity |
| serialIn | input | 1 | Serial receive line |
| serialOut | output | 1 | Serial transmit line |
| rtsOut | output | 1 | Request-to-send output |

## Verification
The assertions assume these things about the inputs:
- `baudWord`, `parityOn` and `parityEven` change only while both directions are idle.
- The receive divisor is at least 3, so that a half-bit point exists.

The stimulus changes these settings only between frames, after `txEmpty` has returned and the driven line has been idle for at least two bit times. It also uses divisors of 5, 7 and 9, which leave a clear margin around every sampling point.

// File: rtl/duart_pkg.sv
package duart_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } phase_t;

  // Strobes from the sequencer to the datapath, all one cycle wide
  typedef struct packed {
    logic txLoad;    // move holding register into the shifter
    logic txShift;   // advance the transmit shifter by one bit
    logic rxShift;   // take one data bit from the line
    logic rxParity;  // take the parity bit from the line
    logic rxDone;    // stop bit sampled now: store or flag the frame
  } strobe_t;

endpackage

// File: rtl/duart_ctrl.sv
module duart_ctrl
  import duart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softReset,
  input  logic [DIV_W-1:0] txDiv,
  input  logic [DIV_W-1:0] rxDiv,
  input  logic             txEnable,
  input  logic             rxEnable,
  input  logic             txBreak,
  input  logic             parityOn,
  input  logic             holdFull,
  input  logic             rxLine,
  input  logic             rxFall,
  output phase_t           txPhase,
  output strobe_t          stb
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  phase_t           rxPhase;
  logic [DIV_W-1:0] txCnt, rxCnt;
  logic [IDX_W-1:0] txIdx, rxIdx;
  logic             txBitEnd, rxBitEnd, rxHalf, txGo;

  assign txBitEnd = (txCnt == txDiv);
  assign rxBitEnd = (rxCnt == rxDiv);
  assign rxHalf   = (rxCnt == (rxDiv >> 1));
  assign txGo     = (txPhase == PH_IDLE) && holdFull && txEnable && !txBreak;

  // Transmit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPhase <= PH_IDLE;
      txCnt   <= '0;
      txIdx   <= '0;
    end else if (softReset) begin
      txPhase <= PH_IDLE;
      txCnt   <= '0;
      txIdx   <= '0;
    end else if (txPhase == PH_IDLE) begin
      if (txGo) begin
        txPhase <= PH_START;
        txCnt   <= '0;
      end
    end else if (txBitEnd) begin
      txCnt <= '0;
      case (txPhase)
        PH_START: begin
          txPhase <= PH_DATA;
          txIdx   <= '0;
        end
        PH_DATA: begin
          if (txIdx == LAST_IDX) txPhase <= parityOn ? PH_PARITY : PH_STOP;
          else                   txIdx   <= txIdx + 1'b1;
        end
        PH_PARITY: txPhase <= PH_STOP;
        default:   txPhase <= PH_IDLE;
      endcase
    end else begin
      txCnt <= txCnt + 1'b1;
    end
  end

  // Receive sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPhase <= PH_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else if (softReset || !rxEnable) begin
      rxPhase <= PH_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else begin
      case (rxPhase)
        PH_IDLE: begin
          if (rxFall) begin
            rxPhase <= PH_START;
            rxCnt   <= '0;
          end
        end
        PH_START: begin
          if (rxHalf) begin
            rxCnt   <= '0;
            rxIdx   <= '0;
            rxPhase <= rxLine ? PH_IDLE : PH_DATA;  // glitch rejected
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        default: begin
          if (rxBitEnd) begin
            rxCnt <= '0;
            case (rxPhase)
              PH_DATA: begin
                if (rxIdx == LAST_IDX) rxPhase <= parityOn ? PH_PARITY : PH_STOP;
                else                   rxIdx   <= rxIdx + 1'b1;
              end
              PH_PARITY: rxPhase <= PH_STOP;
              default:   rxPhase <= PH_IDLE;
            endcase
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.txLoad   = txGo && !softReset;
    stb.txShift  = (txPhase == PH_DATA) && txBitEnd && !softReset;
    stb.rxShift  = (rxPhase == PH_DATA) && rxBitEnd && rxEnable && !softReset;
    stb.rxParity = (rxPhase == PH_PARITY) && rxBitEnd && rxEnable && !softReset;
    stb.rxDone   = (rxPhase == PH_STOP) && rxBitEnd && rxEnable && !softReset;
  end

  // R2: the bit timer never runs past the programmed divisor
  a_r2_tx_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (txPhase != PH_IDLE) |-> (txCnt <= txDiv));

  // R6: an idle transmitter stays idle while a break is held
  a_r6_break_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (txPhase == PH_IDLE) && txBreak |=> (txPhase == PH_IDLE));

  // R7: a disabled receiver is parked in idle on the next cycle
  a_r7_rx_parked: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (rxPhase == PH_IDLE));

  // R13: soft reset aborts both directions
  a_r13_soft_abort: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (txPhase == PH_IDLE) && (rxPhase == PH_IDLE));

endmodule

// File: rtl/duart_dp.sv
module duart_dp
  import duart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softReset,
  input  strobe_t           stb,
  input  phase_t            txPhase,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic              parityOn,
  input  logic              parityEven,
  input  logic              txBreak,
  input  logic              loopMode,
  input  logic              serialIn,
  input  logic              rtsReq,
  output logic              holdFull,
  output logic              rxLine,
  output logic              rxFall,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              rxOverrun,
  output logic              frameErr,
  output logic              serialOut,
  output logic              rtsOut
);

  logic [DATA_W-1:0] holdReg, txSh, rxSh;
  logic              txPar, txLine, lineOut, rxSrc;
  logic              syncA, syncB, rxPrev, rxParSeen, parExp, frameBad;

  // Holding register and transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      txSh     <= '0;
      txPar    <= 1'b0;
    end else if (softReset) begin
      holdFull <= 1'b0;
    end else begin
      if (stb.txLoad) begin
        holdFull <= 1'b0;
        txSh     <= holdReg;
        txPar    <= parityEven ? ^holdReg : ~^holdReg;
      end else if (stb.txShift) begin
        txSh <= txSh >> 1;
      end
      if (txWrite && !holdFull) begin
        holdReg  <= txData;
        holdFull <= 1'b1;
      end
    end
  end

  always_comb begin
    case (txPhase)
      PH_START:  txLine = 1'b0;
      PH_DATA:   txLine = txSh[0];
      PH_PARITY: txLine = txPar;
      default:   txLine = 1'b1;
    endcase
  end

  assign lineOut   = txBreak ? 1'b0 : txLine;
  assign serialOut = loopMode ? 1'b1 : lineOut;
  assign rxSrc     = loopMode ? lineOut : serialIn;

  // Line synchroniser and edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= 1'b1;
      syncB  <= 1'b1;
      rxPrev <= 1'b1;
      rtsOut <= 1'b0;
    end else begin
      syncA  <= rxSrc;
      syncB  <= syncA;
      rxPrev <= syncB;
      rtsOut <= rtsReq;
    end
  end

  assign rxLine = syncB;
  assign rxFall = rxPrev && !syncB;

  assign parExp   = parityEven ? ^rxSh : ~^rxSh;
  assign frameBad = !rxLine || (parityOn && (rxParSeen != parExp));

  // Receive shifter and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh      <= '0;
      rxParSeen <= 1'b0;
      rxData    <= '0;
      rxReady   <= 1'b0;
      rxOverrun <= 1'b0;
      frameErr  <= 1'b0;
    end else if (softReset) begin
      rxReady   <= 1'b0;
      rxOverrun <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      if (stb.rxShift)  rxSh      <= {rxLine, rxSh[DATA_W-1:1]};
      if (stb.rxParity) rxParSeen <= rxLine;
      if (rxRead) begin
        rxReady   <= 1'b0;
        rxOverrun <= 1'b0;
        frameErr  <= 1'b0;
      end
      if (stb.rxDone) begin
        if (rxReady && !rxRead) begin
          rxOverrun <= 1'b1;
        end else begin
          rxData   <= rxSh;
          rxReady  <= 1'b1;
          frameErr <= frameBad;
        end
      end
    end
  end

  // R8: a new byte only appears on a stop-bit sample
  a_r8_ready_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(stb.rxDone));

  // R9: an overrunning frame leaves the unread byte untouched
  a_r9_overrun_discard: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxDone && rxReady && !rxRead && !softReset |=> $stable(rxData) && rxOverrun);

  // R5: a write into a full holding register changes nothing
  a_r5_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    txWrite && holdFull && !stb.txLoad && !softReset |=> $stable(holdReg) && holdFull);

endmodule

// File: rtl/dual_rate_uart.sv
module dual_rate_uart
  import duart_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 15,
  parameter int RX_DIV_LSB = 16,
  parameter int WORD_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] baudWord,
  input  logic              parityOn,
  input  logic              parityEven,
  input  logic              rtsReq,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              txBreak,
  input  logic              loopMode,
  input  logic              softReset,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              txReady,
  output logic              txEmpty,
  output logic              rxOverrun,
  output logic              frameErr,
  input  logic              serialIn,
  output logic              serialOut,
  output logic              rtsOut
);

  logic [DIV_W-1:0] txDiv, rxDiv;
  logic             unusedBaudBits;
  phase_t           txPhase;
  strobe_t          stb;
  logic             holdFull, rxLine, rxFall;

  assign txDiv          = baudWord[DIV_W-1:0];
  assign rxDiv          = baudWord[RX_DIV_LSB +: DIV_W];
  assign unusedBaudBits = ^{baudWord[DIV_W], baudWord[WORD_W-1]};

  duart_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .softReset(softReset),
    .txDiv(txDiv), .rxDiv(rxDiv),
    .txEnable(txEnable), .rxEnable(rxEnable), .txBreak(txBreak),
    .parityOn(parityOn), .holdFull(holdFull),
    .rxLine(rxLine), .rxFall(rxFall),
    .txPhase(txPhase), .stb(stb)
  );

  duart_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .softReset(softReset), .stb(stb), .txPhase(txPhase),
    .txWrite(txWrite), .txData(txData), .rxRead(rxRead),
    .parityOn(parityOn), .parityEven(parityEven), .txBreak(txBreak),
    .loopMode(loopMode), .serialIn(serialIn), .rtsReq(rtsReq),
    .holdFull(holdFull), .rxLine(rxLine), .rxFall(rxFall),
    .rxData(rxData), .rxReady(rxReady), .rxOverrun(rxOverrun),
    .frameErr(frameErr), .serialOut(serialOut), .rtsOut(rtsOut)
  );

  assign txReady = !holdFull;
  assign txEmpty = !holdFull && (txPhase == PH_IDLE);

endmodule

// File: tb/dual_rate_uart_tb.sv
`timescale 1ns/1ps
module dual_rate_uart_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] baudWord;
  logic        parityOn = 0, parityEven = 0, rtsReq = 0, txEnable = 1, rxEnable = 1;
  logic        txBreak = 0, loopMode = 0, softReset = 0, txWrite = 0, rxRead = 0;
  logic [7:0]  txData = '0;
  logic [7:0]  rxData;
  logic        rxReady, txReady, txEmpty, rxOverrun, frameErr, serialOut, rtsOut;
  logic        benchLine = 1'b1, extLoop = 1'b0;
  logic        serialIn;

  int vecs = 0, miss = 0;
  bit done = 0;

  assign serialIn = extLoop ? serialOut : benchLine;

  always #2.5 clk = ~clk;

  dual_rate_uart u_dut (
    .clk(clk), .rstN(rstN), .baudWord(baudWord), .parityOn(parityOn),
    .parityEven(parityEven), .rtsReq(rtsReq), .txEnable(txEnable),
    .rxEnable(rxEnable), .txBreak(txBreak), .loopMode(loopMode),
    .softReset(softReset), .txWrite(txWrite), .txData(txData), .rxRead(rxRead),
    .rxData(rxData), .rxReady(rxReady), .txReady(txReady), .txEmpty(txEmpty),
    .rxOverrun(rxOverrun), .frameErr(frameErr), .serialIn(serialIn),
    .serialOut(serialOut), .rtsOut(rtsOut)
  );

  // {parity on, even select, data byte}
  localparam logic [9:0] VEC [0:7] = '{10'h000, 10'h0FF, 10'h3A5, 10'h2A5,
                                       10'h301, 10'h280, 10'h13C, 10'h200};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic putByte(input logic [7:0] d);
    txData = d; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic takeByte();
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
  endtask

  task automatic waitTxIdle();
    int g = 0;
    while (!txEmpty && g < 5000) begin @(negedge clk); g++; end
    tick(4);
  endtask

  task automatic waitRx();
    int g = 0;
    while (!rxReady && g < 2000) begin @(negedge clk); g++; end
  endtask

  // Decode one frame from serialOut, sampling mid-bit
  task automatic capTx(input int cpb, input bit withPar,
                       output logic [7:0] d, output logic p, output logic s);
    int g = 0;
    while (serialOut !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
    repeat (cpb / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (cpb) @(negedge clk);
      d[i] = serialOut;
    end
    p = 1'b0;
    if (withPar) begin
      repeat (cpb) @(negedge clk);
      p = serialOut;
    end
    repeat (cpb) @(negedge clk);
    s = serialOut;
  endtask

  // Drive one frame onto serialIn
  task automatic sendRx(input int cpb, input logic [7:0] d, input bit withPar,
                        input logic p, input logic s);
    benchLine = 1'b0; tick(cpb);
    for (int i = 0; i < 8; i++) begin benchLine = d[i]; tick(cpb); end
    if (withPar) begin benchLine = p; tick(cpb); end
    benchLine = s; tick(cpb);
    benchLine = 1'b1; tick(2 * cpb);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miss++; vecs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic p, s, expPar;
    int cnt;
    baudWord = {1'b0, 15'd7, 1'b0, 15'd7};
    tick(5);
    rstN = 1'b1;
    tick(2);

    // R1 reset state
    chk("R1 serialOut", serialOut, 1); chk("R1 txReady", txReady, 1);
    chk("R1 txEmpty", txEmpty, 1);     chk("R1 rxReady", rxReady, 0);
    chk("R1 rxOverrun", rxOverrun, 0); chk("R1 frameErr", frameErr, 0);
    chk("R1 rtsOut", rtsOut, 0);

    // Vector table: external loop, line decoded and received (R3 R4 R8)
    extLoop = 1'b1;
    for (int v = 0; v < 8; v++) begin
      parityOn = VEC[v][9]; parityEven = VEC[v][8];
      tick(1);
      putByte(VEC[v][7:0]);
      capTx(8, VEC[v][9], d, p, s);
      expPar = VEC[v][8] ? ^VEC[v][7:0] : ~^VEC[v][7:0];
      chk("R3 data on line", d, VEC[v][7:0]);
      if (VEC[v][9]) chk("R4 parity bit", p, expPar);
      chk("R3 stop bit", s, 1);
      waitRx();
      chk("R8 rxReady", rxReady, 1);
      chk("R8 rxData", rxData, VEC[v][7:0]);
      chk("R10 no frame error", frameErr, 0);
      takeByte();
      chk("R8 read clears", rxReady, 0);
      waitTxIdle();
    end
    extLoop = 1'b0; parityOn = 0; parityEven = 0;

    // R2 independent divisors: tx 6 clocks/bit, rx 10 clocks/bit
    baudWord = {1'b0, 15'd9, 1'b0, 15'd5};
    tick(2);
    putByte(8'h01);
    cnt = 0;
    while (serialOut === 1'b1) @(negedge clk);
    while (serialOut === 1'b0 && cnt < 100) begin cnt++; @(negedge clk); end
    chk("R2 tx start bit width", cnt, 6);
    waitTxIdle();
    sendRx(10, 8'hC3, 0, 0, 1);
    chk("R2 rx divisor receive", rxData, 8'hC3);
    chk("R2 rx ready", rxReady, 1);
    takeByte();
    baudWord = {1'b0, 15'd7, 1'b0, 15'd7};
    tick(2);

    // R5 holding register and ignored write
    putByte(8'h3A);
    chk("R5 txReady after write", txReady, 0);
    tick(1);
    chk("R5 txReady after load", txReady, 1);
    chk("R5 txEmpty while sending", txEmpty, 0);
    putByte(8'hB6);
    chk("R5 txReady holding full", txReady, 0);
    putByte(8'h99);
    capTx(8, 0, d, p, s);
    chk("R5 first frame", d, 8'h3A);
    capTx(8, 0, d, p, s);
    chk("R5 second frame not overwritten", d, 8'hB6);
    waitTxIdle();
    cnt = 0;
    for (int i = 0; i < 120; i++) begin if (serialOut !== 1'b1) cnt++; @(negedge clk); end
    chk("R5 ignored write never sent", cnt, 0);
    chk("R5 txEmpty at end", txEmpty, 1);

    // R6 break
    txBreak = 1'b1;
    tick(1);
    putByte(8'h24);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin if (serialOut !== 1'b0) cnt++; @(negedge clk); end
    chk("R6 line held low", cnt, 0);
    chk("R6 byte held", txReady, 0);
    chk("R6 not empty", txEmpty, 0);
    txBreak = 1'b0;
    capTx(8, 0, d, p, s);
    chk("R6 byte sent after break", d, 8'h24);
    waitTxIdle();

    // R7 transmit disable
    txEnable = 1'b0;
    putByte(8'h42);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin if (serialOut !== 1'b1) cnt++; @(negedge clk); end
    chk("R7 no frame while disabled", cnt, 0);
    chk("R7 byte still held", txReady, 0);
    txEnable = 1'b1;
    capTx(8, 0, d, p, s);
    chk("R7 frame after enable", d, 8'h42);
    waitTxIdle();

    // R7 receive disable
    rxEnable = 1'b0;
    sendRx(8, 8'h99, 0, 0, 1);
    chk("R7 rx ignores line", rxReady, 0);
    rxEnable = 1'b1;
    tick(2);
    sendRx(8, 8'h66, 0, 0, 1);
    chk("R7 rx after enable", rxData, 8'h66);
    takeByte();

    // R9 overrun
    sendRx(8, 8'h11, 0, 0, 1);
    sendRx(8, 8'h22, 0, 0, 1);
    chk("R9 overrun flag", rxOverrun, 1);
    chk("R9 old byte kept", rxData, 8'h11);
    takeByte();
    chk("R9 read clears overrun", rxOverrun, 0);
    chk("R8 read clears ready", rxReady, 0);

    // R10 framing and parity faults
    sendRx(8, 8'h7E, 0, 0, 0);
    chk("R10 low stop flagged", frameErr, 1);
    chk("R10 byte stored", rxData, 8'h7E);
    takeByte();
    chk("R8 read clears frameErr", frameErr, 0);
    parityOn = 1'b1; parityEven = 1'b1;
    sendRx(8, 8'h03, 1, 1, 1);
    chk("R10 parity mismatch flagged", frameErr, 1);
    takeByte();
    sendRx(8, 8'h07, 1, 1, 1);
    chk("R4 good even parity accepted", frameErr, 0);
    chk("R4 parity frame data", rxData, 8'h07);
    takeByte();
    parityOn = 1'b0; parityEven = 1'b0;

    // R11 loopback, external input held low
    loopMode = 1'b1; benchLine = 1'b0;
    tick(4);
    putByte(8'h5A);
    cnt = 0;
    for (int i = 0; i < 130; i++) begin if (serialOut !== 1'b1) cnt++; @(negedge clk); end
    chk("R11 serialOut idle in loopback", cnt, 0);
    chk("R11 loopback rxReady", rxReady, 1);
    chk("R11 loopback rxData", rxData, 8'h5A);
    takeByte();
    benchLine = 1'b1; loopMode = 1'b0;
    tick(4);

    // R12 request to send
    rtsReq = 1'b1; tick(1);
    chk("R12 rts high", rtsOut, 1);
    rtsReq = 1'b0; tick(1);
    chk("R12 rts low", rtsOut, 0);

    // R13 soft reset
    sendRx(8, 8'hE1, 0, 0, 1);
    putByte(8'h81);
    putByte(8'h18);
    tick(20);
    softReset = 1'b1; tick(1); softReset = 1'b0;
    chk("R13 line idle", serialOut, 1);
    chk("R13 txReady", txReady, 1);
    chk("R13 txEmpty", txEmpty, 1);
    chk("R13 rxReady cleared", rxReady, 0);
    cnt = 0;
    for (int i = 0; i < 120; i++) begin if (serialOut !== 1'b1) cnt++; @(negedge clk); end
    chk("R13 nothing sent after reset", cnt, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule